// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

This block sits between an instruction queue and a row of parallel decoders. Every queued instruction arrives tagged with the number of micro-operations it expands to. Each clock the block looks at the head of the queue and forms a decode group, handing instructions out in strict program order. Slot 0 feeds the only complex decoder. The remaining slots feed simple decoders, and the number of simple slots is a parameter. The block tells the queue how many entries to pop in the same cycle. One cycle later it presents, for each slot, a valid bit and the micro-op count of the instruction it holds.

Only slot 0 accepts an instruction of more than one micro-op, so any multi-op instruction that is not at the head closes the current group. Instructions larger than the complex decoder can expand are passed to a microcode sequencer through a request/done handshake. A downstream stall freezes allocation. An instruction claiming zero micro-ops is reported as an error.

Top module: `dsa_slot_alloc`

## Requirements
- R1: A valid head entry whose count (3-bit field) is 1 to 4 is placed in slot 0, and slot 0 then reports that count.
- R2: A slot k ≥ 1 only takes entry k, and only when that entry is valid, holds a count of exactly 1, and every earlier slot was filled this cycle. The first entry that fails these conditions ends the group.
- R3: The counts placed in one group never add up to more than 4 micro-ops.
- R4: The group holds at most NSIMPLE+1 instructions. With NSIMPLE=2, the count sequence 2,2,1,1,1 needs three cycles to drain and 2,1,2,1,1 needs two.
- R5: `pop_cnt` shows the group size combinationally in the cycle the entries are presented. The slot outputs show that group after the next rising edge. Slots are filled from 0 upward without gaps. Entry k uses bits [3k+2:3k] of `ent_uops`, and slot k uses the same bits of `slot_uops`.
- R6: A valid head with a count of 5 to 7 pops exactly that one entry and fills no slot. `ucode_req` is high from the next cycle until the cycle after `ucode_done` is sampled high, and `pop_cnt` is 0 during that time.
- R7: A valid head with a count of 0 pops nothing and fills no slot. `uop_err` is high in the following cycle.
- R8: While `stall` is high, `pop_cnt` is 0 and, in the following cycle, all slots are invalid.
- R9: After reset, `ucode_req` and `uop_err` are low and all slots are invalid, even if the reset arrived while a microcode request was pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Downstream stall: freezes allocation |
| ent_vld | input | NQ | Valid bit per queue entry, bit 0 is the oldest |
| ent_uops | input | NQ*3 | Micro-op count per queue entry |
| ucode_done | input | 1 | Microcode sequencer has finished |
| pop_cnt | output | clog2(NQ+1) | Entries the queue must pop this cycle |
| slot_vld | output | NSIMPLE+1 | Valid bit per decoder slot |
| slot_uops | output | (NSIMPLE+1)*3 | Micro-op count per decoder slot |
| ucode_req | output | 1 | Microcode request pending |
| uop_err | output | 1 | Head entry carried an illegal zero count |

## Verification
The pop count is combinational, so the bench reads it a short delay after driving entries at a falling edge, before the rising edge that consumes them. Slot contents, the error flag and the microcode request all pass through a single register. The bench therefore samples them at the next falling edge, one full cycle after the stimulus. For the handshake, the bench checks that the request drops one cycle after `done` is applied. Two instances, with two and with three simple slots, are swept together over every count pattern of a four-entry window and over every valid mask. Each is compared against an arithmetic reference.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    parameter int UOP_W       = 3;
    parameter int COMPLEX_MAX = 4;
    parameter int ISSUE_CAP   = 4;

    typedef enum logic {
        ST_ALLOC = 1'b0,
        ST_UCODE = 1'b1
    } dsa_state_e;
endpackage

// File: rtl/dsa_group_form.sv
module dsa_group_form
    import dsa_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int NSIMPLE = 2,
    localparam int NSLOT  = NSIMPLE + 1,
    localparam int CW     = $clog2(NQ + 1)
) (
    input  logic [NQ-1:0]       ent_vld,
    input  logic [NQ*UOP_W-1:0] ent_uops,
    output logic [NSLOT-1:0]    take,
    output logic                head_big,
    output logic                head_zero,
    output logic [CW-1:0]       grp_n
);
    logic [UOP_W-1:0] head_u;
    assign head_u    = ent_uops[UOP_W-1:0];
    assign head_big  = ent_vld[0] && (int'(head_u) > COMPLEX_MAX);
    assign head_zero = ent_vld[0] && (head_u == '0);
    assign take[0]   = ent_vld[0] && !head_big && !head_zero;

    // Simple slots: strict order, single-op only, issue cap respected.
    for (genvar k = 1; k < NSLOT; k++) begin : g_simple
        if (k < NQ) begin : g_real
            logic [UOP_W-1:0] u_k;
            assign u_k     = ent_uops[k*UOP_W +: UOP_W];
            assign take[k] = take[k-1] && ent_vld[k] && (u_k == UOP_W'(1))
                             && (int'(head_u) + k <= ISSUE_CAP);
        end else begin : g_none
            assign take[k] = 1'b0;
        end
    end

    always_comb begin
        grp_n = '0;
        if (head_big) begin
            grp_n = CW'(1);
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                grp_n = grp_n + CW'(take[i]);
            end
        end
    end
endmodule

// File: rtl/dsa_ucode_ctl.sv
module dsa_ucode_ctl
    import dsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);
    dsa_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_ALLOC: if (start) state_d = ST_UCODE;
            ST_UCODE: if (done)  state_d = ST_ALLOC;
            default:             state_d = ST_ALLOC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ALLOC;
        else        state_q <= state_d;
    end

    assign busy = (state_q == ST_UCODE);

    assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);
endmodule

// File: rtl/dsa_slot_alloc.sv
module dsa_slot_alloc
    import dsa_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int NSIMPLE = 2,
    localparam int NSLOT  = NSIMPLE + 1,
    localparam int CW     = $clog2(NQ + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic [NQ-1:0]          ent_vld,
    input  logic [NQ*UOP_W-1:0]    ent_uops,
    input  logic                   ucode_done,
    output logic [CW-1:0]          pop_cnt,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [NSLOT*UOP_W-1:0] slot_uops,
    output logic                   ucode_req,
    output logic                   uop_err
);
    typedef struct packed {
        logic [NSLOT-1:0]       vld;
        logic [NSLOT*UOP_W-1:0] uops;
        logic                   err;
    } alloc_reg_t;

    alloc_reg_t r_d, r_q;

    logic [NSLOT-1:0] take;
    logic             head_big;
    logic             head_zero;
    logic [CW-1:0]    grp_n;
    logic             ucode_busy;
    logic             alloc_en;

    dsa_group_form #(.NQ(NQ), .NSIMPLE(NSIMPLE)) u_form (
        .ent_vld   (ent_vld),
        .ent_uops  (ent_uops),
        .take      (take),
        .head_big  (head_big),
        .head_zero (head_zero),
        .grp_n     (grp_n)
    );

    dsa_ucode_ctl u_ucode (
        .clk   (clk),
        .rst_n (rst_n),
        .start (alloc_en && head_big),
        .done  (ucode_done),
        .busy  (ucode_busy)
    );

    assign alloc_en = !stall && !ucode_busy;
    assign pop_cnt  = alloc_en ? grp_n : '0;

    always_comb begin
        r_d = '0;
        for (int k = 0; k < NSLOT; k++) begin
            r_d.vld[k] = alloc_en && take[k];
            if (alloc_en && take[k] && (k < NQ)) begin
                r_d.uops[k*UOP_W +: UOP_W] = ent_uops[k*UOP_W +: UOP_W];
            end
        end
        r_d.err = alloc_en && head_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign slot_vld  = r_q.vld;
    assign slot_uops = r_q.uops;
    assign uop_err   = r_q.err;
    assign ucode_req = ucode_busy;

    // Assertion helper: micro-op total of the registered group.
    int unsigned grp_sum;
    always_comb begin
        grp_sum = 0;
        for (int k = 0; k < NSLOT; k++) begin
            grp_sum += r_q.vld[k] ? int'(r_q.uops[k*UOP_W +: UOP_W]) : 0;
        end
    end

    assert_issue_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_sum <= ISSUE_CAP);

    assert_head_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[0] |-> (slot_uops[UOP_W-1:0] != '0 &&
                         int'(slot_uops[UOP_W-1:0]) <= COMPLEX_MAX));

    for (genvar k = 1; k < NSLOT; k++) begin : g_chk
        assert_simple_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[k] |-> (slot_uops[k*UOP_W +: UOP_W] == UOP_W'(1)));
        assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[k] |-> slot_vld[k-1]);
    end

    assert_ucode_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ucode_req |-> (pop_cnt == '0));

    assert_ucode_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ucode_req) |-> ($past(pop_cnt) == CW'(1) && slot_vld == '0));

    assert_err_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uop_err |-> (slot_vld == '0));

    assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (slot_vld == '0));
endmodule

// File: tb/tb_dsa_slot_alloc.sv
module tb_dsa_slot_alloc;
    localparam int NQ = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic stall;
    logic [NQ-1:0] ent_vld;
    logic [NQ*3-1:0] ent_uops;
    logic ucode_done;

    logic [2:0]  pop2, pop3;
    logic [2:0]  sv2;
    logic [3:0]  sv3;
    logic [8:0]  su2;
    logic [11:0] su3;
    logic req2, req3, err2, err3;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dsa_slot_alloc #(.NQ(NQ), .NSIMPLE(2)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .ent_vld(ent_vld),
        .ent_uops(ent_uops), .ucode_done(ucode_done), .pop_cnt(pop2),
        .slot_vld(sv2), .slot_uops(su2), .ucode_req(req2), .uop_err(err2));

    dsa_slot_alloc #(.NQ(NQ), .NSIMPLE(3)) dut3 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .ent_vld(ent_vld),
        .ent_uops(ent_uops), .ucode_done(ucode_done), .pop_cnt(pop3),
        .slot_vld(sv3), .slot_uops(su3), .ucode_req(req3), .uop_err(err3));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference group size from the requirements (0 when head not decodable).
    function automatic int ref_n(int ns, logic [3:0] v, logic [11:0] u);
        int h, n;
        h = int'(u[2:0]);
        if (!v[0] || h == 0 || h > 4) return 0;
        n = 1;
        for (int k = 1; k <= ns; k++) begin
            if (k < NQ && v[k] && u[k*3 +: 3] == 3'd1 && h + k <= 4) n++;
            else break;
        end
        return n;
    endfunction

    function automatic logic [11:0] ref_u(int n, logic [11:0] u);
        logic [11:0] r = '0;
        for (int k = 0; k < n; k++) r[k*3 +: 3] = u[k*3 +: 3];
        return r;
    endfunction

    // One allocation case, checked on both instances.
    task automatic run_case(input logic [3:0] v, input logic [11:0] u);
        int n2, n3, h, ep2, ep3;
        bit big, zero;
        @(negedge clk);
        stall = 1'b0; ent_vld = v; ent_uops = u;
        h = int'(u[2:0]);
        big  = v[0] && h > 4;
        zero = v[0] && h == 0;
        n2 = ref_n(2, v, u);
        n3 = ref_n(3, v, u);
        ep2 = big ? 1 : n2;
        ep3 = big ? 1 : n3;
        #2;
        chk(pop2 == 3'(ep2), "R5 pop count ns2", int'(pop2), ep2);
        chk(pop3 == 3'(ep3), "R4 pop count ns3", int'(pop3), ep3);
        @(negedge clk);
        ent_vld = '0;
        chk(sv2 == 3'((1 << n2) - 1), "R2 slot valid ns2", int'(sv2), (1 << n2) - 1);
        chk(sv3 == 4'((1 << n3) - 1), "R3 slot valid ns3", int'(sv3), (1 << n3) - 1);
        chk(su2 == ref_u(n2, u)[8:0], "R1 slot uops ns2", int'(su2), int'(ref_u(n2, u)[8:0]));
        chk(su3 == ref_u(n3, u), "R1 slot uops ns3", int'(su3), int'(ref_u(n3, u)));
        chk(err2 == zero && err3 == zero, "R7 zero count error", int'(err2), int'(zero));
        chk(req2 == big && req3 == big, "R6 microcode request", int'(req2), int'(big));
        if (big) begin
            ent_vld = 4'hF; ent_uops = 12'h249;
            #2;
            chk(pop2 == 0 && pop3 == 0, "R6 no pop while busy", int'(pop2), 0);
            @(negedge clk);
            chk(req2 && req3, "R6 request held", int'(req2), 1);
            ucode_done = 1'b1;
            @(negedge clk);
            ucode_done = 1'b0; ent_vld = '0;
            chk(!req2 && !req3, "R6 request released", int'(req2), 0);
        end
    endtask

    task automatic drain(input int ns, input int cnt[5], output int cycles);
        int ptr = 0;
        cycles = 0;
        while (ptr < 5 && cycles < 20) begin
            @(negedge clk);
            stall = 1'b0;
            for (int k = 0; k < NQ; k++) begin
                ent_vld[k] = (ptr + k < 5);
                ent_uops[k*3 +: 3] = (ptr + k < 5) ? 3'(cnt[ptr + k]) : 3'd0;
            end
            #2;
            ptr += (ns == 2) ? int'(pop2) : int'(pop3);
            cycles++;
        end
        @(negedge clk);
        ent_vld = '0;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int cyc;
        int seq_a[5] = '{2, 2, 1, 1, 1};
        int seq_b[5] = '{2, 1, 2, 1, 1};
        rst_n = 1'b0; stall = 1'b0; ent_vld = '0; ent_uops = '0; ucode_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sv2 == 0 && sv3 == 0 && !req2 && !err2, "R9 reset state", int'(sv2), 0);

        // Every count pattern in the window, all entries valid.
        for (int p = 0; p < 4096; p++) run_case(4'hF, 12'(p));
        // Every valid mask over single-op and mixed counts.
        for (int m = 0; m < 16; m++) begin
            run_case(4'(m), 12'h249);
            run_case(4'(m), 12'h24A);
        end

        // R4 drain sequences
        drain(2, seq_a, cyc);
        chk(cyc == 3, "R4 sequence 2,2,1,1,1", cyc, 3);
        drain(2, seq_b, cyc);
        chk(cyc == 2, "R4 sequence 2,1,2,1,1", cyc, 2);

        // R8 stall
        @(negedge clk);
        stall = 1'b1; ent_vld = 4'hF; ent_uops = 12'h249;
        #2;
        chk(pop2 == 0 && pop3 == 0, "R8 stall pop", int'(pop2), 0);
        @(negedge clk);
        chk(sv2 == 0 && sv3 == 0, "R8 stall slots", int'(sv2), 0);
        stall = 1'b0; ent_vld = '0;

        // R9 reset during a pending microcode request
        @(negedge clk);
        ent_vld = 4'h1; ent_uops = 12'h006;
        @(negedge clk);
        ent_vld = '0;
        chk(req2 == 1'b1, "R6 request before reset", int'(req2), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req2 && !req3 && sv2 == 0, "R9 reset clears request", int'(req2), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule